// File: doc/BRIEF.md
# Shared-Timebase PWM Channel Bank

This block drives a bank of pulse-width channels from one free-running counter. The counter steps once per clock while the block is enabled and wraps from its all-ones value back to zero. So every channel has the same period of 2^CNT_W clocks. Each channel compares the counter with its own duty input. The channel output is high at the start of every period and drops once the counter reaches the duty value. This gives a left-aligned, non-inverted square wave.

The block also has these outputs:
- **Composite outputs.** For each adjacent channel pair, the XOR of the two channel waveforms.
- **Wrap interrupt.** A one-clock pulse once per period, on the last count.
- **Compare strobe.** A one-clock pulse when the counter equals the duty value of channel 0.

Duty values come from an update stage outside this block, which keeps them glitch-free. All outputs are registered. The `phase_o` port shows the counter value that the current outputs were computed from, so anyone watching the outputs can line them up with the period.

Top module: `pwmx_bank`

## Requirements
- R1: While `en_i` is high, `phase_o` advances by one each clock and wraps from 2^CNT_W-1 to 0. The first output cycle after enabling shows phase 0.
- R2: Channel i's output is high exactly when `phase_o` is less than its duty value. Duty i occupies bits [i*CNT_W +: CNT_W] of `duty_i`. A duty of 0 keeps the output low for the whole period.
- R3: A duty of all ones keeps the output high on every phase except the last one (2^CNT_W-1).
- R4: `pair_o[k]` equals `pwm_o[2k]` XOR `pwm_o[2k+1]` on every cycle.
- R5: `wrap_irq_o` is high for exactly one cycle per period: the cycle in which `phase_o` equals 2^CNT_W-1.
- R6: `ch0_evt_o` is high exactly in the cycles where `phase_o` equals the duty value of channel 0. With a duty of 0, that is phase 0.
- R7: The clock after `en_i` is low, `phase_o`, every channel output, every pair output, the interrupt and the strobe are all 0. Counting restarts from 0 once the block is enabled again.
- R8: Synchronous active-high `rst` clears every output and the counter.
- R9: Duty inputs are not latched. A new duty value takes effect at the very next clock edge, even in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; when low, the counter holds at 0 and all outputs are low |
| duty_i | input | NUM_CH*CNT_W | Packed active duty values, channel i at [i*CNT_W +: CNT_W] |
| phase_o | output | CNT_W | Counter value that the current outputs reflect |
| pwm_o | output | NUM_CH | Per-channel waveforms |
| pair_o | output | NUM_CH/2 | XOR composites of channel pairs (2k, 2k+1) |
| wrap_irq_o | output | 1 | One-cycle pulse on the last count of each period |
| ch0_evt_o | output | 1 | One-cycle strobe when the phase equals channel 0's duty |

## Verification
The assertions check several things on every clock:
- the counter steps by one while enabled and holds at zero while disabled;
- each composite output matches the XOR of its two channel outputs;
- the interrupt coincides with the terminal phase and never lasts two cycles;
- a zero duty never produces a high output;
- the strobe stays quiet after a disabled cycle.

The exact duty comparison can only be shown by the bench's scenarios. These sweep full periods against a counter model, using boundary duties (0, 1, mid-scale, top-1, top) and a channel-0 strobe position. The bench scenarios also cover a duty that changes on every clock, and disable/re-enable in mid-period.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  parameter int DEF_CNT_W  = 12;
  parameter int DEF_NUM_CH = 8;
endpackage

// File: rtl/pwmx_timebase.sv
module pwmx_timebase #(
  parameter int CW = pwmx_pkg::DEF_CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] phase_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] phase_q;
  logic          wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else if (en_i) begin
      cnt_q   <= cnt_q + 1'b1;
      phase_q <= cnt_q;
      wrap_q  <= (cnt_q == TOP);
    end else begin
      cnt_q   <= '0;
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;
  assign wrap_o  = wrap_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    en_i |=> cnt_q == CW'($past(cnt_q) + 1'b1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_q == '0 && phase_q == '0)); // R7
  AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> phase_q == TOP); // R5
  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wrap_q |=> !wrap_q); // R5
endmodule

// File: rtl/pwmx_channel.sv
module pwmx_channel #(
  parameter int CW = pwmx_pkg::DEF_CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] duty_i,
  output logic          hit_o,
  output logic          pwm_o
);
  logic pwm_q;

  assign hit_o = (cnt_i < duty_i);

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= en_i & hit_o;
  end

  assign pwm_o = pwm_q;

  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
    (duty_i == '0) |=> !pwm_q); // R2
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pwm_q); // R7
endmodule

// File: rtl/pwmx_bank.sv
module pwmx_bank #(
  parameter int CNT_W  = pwmx_pkg::DEF_CNT_W,
  parameter int NUM_CH = pwmx_pkg::DEF_NUM_CH
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic [NUM_CH*CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0]        phase_o,
  output logic [NUM_CH-1:0]       pwm_o,
  output logic [NUM_CH/2-1:0]     pair_o,
  output logic                    wrap_irq_o,
  output logic                    ch0_evt_o
);
  localparam int NPAIR = NUM_CH / 2;

  logic [CNT_W-1:0]  cnt_w;
  logic [NUM_CH-1:0] hit_w;
  logic [NUM_CH-1:0] pwm_w;
  logic [NPAIR-1:0]  pair_q;
  logic              evt_q;

  pwmx_timebase #(.CW(CNT_W)) u_tb (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .cnt_o   (cnt_w),
    .phase_o (phase_o),
    .wrap_o  (wrap_irq_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwmx_channel #(.CW(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .en_i   (en_i),
      .cnt_i  (cnt_w),
      .duty_i (duty_i[i*CNT_W +: CNT_W]),
      .hit_o  (hit_w[i]),
      .pwm_o  (pwm_w[i])
    );
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) pair_q[k] <= 1'b0;
      else     pair_q[k] <= en_i & (hit_w[2*k] ^ hit_w[2*k+1]);
    end

    AST_PAIR_XOR: assert property (@(posedge clk) disable iff (rst)
      pair_q[k] == (pwm_w[2*k] ^ pwm_w[2*k+1])); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= en_i & (cnt_w == duty_i[CNT_W-1:0]);
  end

  assign pwm_o     = pwm_w;
  assign pair_o    = pair_q;
  assign ch0_evt_o = evt_q;

  AST_EVT_GATED: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !evt_q); // R7
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !wrap_irq_o); // R7
endmodule

// File: tb/sim_pwmx_bank.sv
`timescale 1ns/1ps
module sim_pwmx_bank;
  localparam int CW  = 12;
  localparam int NCH = 8;
  localparam int NP  = NCH / 2;
  localparam logic [CW-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [CW-1:0] d [NCH];
  logic [NCH*CW-1:0] duty_bus;
  logic [CW-1:0] phase;
  logic [NCH-1:0] pwm;
  logic [NP-1:0] pair;
  logic irq, evt;

  int n_cmp = 0;
  int n_bad = 0;
  logic [CW-1:0] mc = '0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) duty_bus[i*CW +: CW] = d[i];
  end

  pwmx_bank #(.CNT_W(CW), .NUM_CH(NCH)) u0 (
    .clk(clk), .rst(rst), .en_i(en), .duty_i(duty_bus),
    .phase_o(phase), .pwm_o(pwm), .pair_o(pair),
    .wrap_irq_o(irq), .ch0_evt_o(evt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Called at a falling edge: drive inputs, predict the next edge, check.
  task automatic step(input logic e);
    logic [CW-1:0] ep;
    logic [NCH-1:0] epwm;
    logic [NP-1:0] epair;
    logic eirq, eevt;
    logic [CW-1:0] nxt;
    en = e;
    if (e) begin
      ep = mc;
      for (int i = 0; i < NCH; i++) epwm[i] = (mc < d[i]);
      eirq = (mc == TOP);
      eevt = (mc == d[0]);
      nxt = mc + 1'b1;
    end else begin
      ep = '0; epwm = '0; eirq = 1'b0; eevt = 1'b0; nxt = '0;
    end
    for (int k = 0; k < NP; k++) epair[k] = epwm[2*k] ^ epwm[2*k+1];
    @(posedge clk); #2;
    check(e ? "R1 phase" : "R7 phase", 32'(phase), 32'(ep));
    for (int i = 0; i < NCH; i++)
      check(!e ? "R7 pwm" : (d[i] == TOP ? "R3 pwm" : "R2 pwm"), 32'(pwm[i]), 32'(epwm[i]));
    check(e ? "R4 pair" : "R7 pair", 32'(pair), 32'(epair));
    check(e ? "R5 irq" : "R7 irq", 32'(irq), 32'(eirq));
    check(e ? "R6 evt" : "R7 evt", 32'(evt), 32'(eevt));
    mc = nxt;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) d[i] = 12'd1000;
    en = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state, with enable already high
    check("R8 phase", 32'(phase), 0);
    check("R8 pwm", 32'(pwm), 0);
    check("R8 pair", 32'(pair), 0);
    check("R8 irq", 32'(irq), 0);
    check("R8 evt", 32'(evt), 0);
    en = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    mc = '0;
    // Set 1: boundary duties, channel 0 at 0 (R2, R3, R6)
    d[0] = 0;    d[1] = 1;    d[2] = 2;    d[3] = 100;
    d[4] = 2048; d[5] = 4094; d[6] = 4095; d[7] = 3000;
    for (int c = 0; c < 4096 + 20; c++) step(1'b1);
    // Set 2: equal pair, top duties, mid strobe
    d[0] = 777;  d[1] = 0;    d[2] = 4095; d[3] = 4095;
    d[4] = 777;  d[5] = 777;  d[6] = 1;    d[7] = 2048;
    for (int c = 0; c < 4096 + 5; c++) step(1'b1);
    // R7: disable mid-period, then re-enable and restart from 0
    for (int c = 0; c < 25; c++) step(1'b0);
    for (int c = 0; c < 300; c++) step(1'b1);
    step(1'b0);
    for (int c = 0; c < 4200; c++) step(1'b1);
    // R9: duty inputs change every clock
    for (int c = 0; c < 4096 + 10; c++) begin
      for (int i = 0; i < NCH; i++) d[i] = CW'(c * (i + 3) + i * 517);
      step(1'b1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule